// File: doc/BRIEF.md
# SIMD Floating-Point Exception Arbiter

This block decides which floating-point exception conditions a packed operation reports. A packed operation is split into two or four lanes. Each lane raises its own raw condition bits, and the block resolves them lane by lane with a fixed six-level precedence and the current mask bits. A condition in one lane never hides a condition in another lane. The reported conditions of all active lanes are merged into six sticky status flags.

When a reported condition is unmasked, the block raises a trap request in the same cycle as the operation strobe, together with a one-hot-per-class cause vector. There is no deferred pending state, so unmasking a flag that is already set never raises a trap by itself.

The sticky flags are cleared only through a per-bit clear input. The arithmetic datapath, how NaN results are formed, and software trap handling all live outside this block.

Top module: `fpx_arbiter`

## Requirements
- R1: Each lane is arbitrated on its own. A condition in one lane never suppresses a condition in another lane. Lane l takes its condition bits from `cond_i[8*l +: 8]`, with bit 0 SNaN-invalid, bit 1 QNaN operand, bit 2 other invalid, bit 3 divide-by-zero, bit 4 denormal, bit 5 overflow, bit 6 underflow and bit 7 inexact.
- R2: The top level is an SNaN operand, or any NaN operand (bit 1) when `any_nan_inv_i` is high. It reports only invalid (flag bit 0) for that lane, whatever the masks are, and blocks every lower condition in that lane.
- R3: A QNaN operand when `any_nan_inv_i` is low sets no flag and blocks every lower condition in its lane. For example, a QNaN with divide-by-zero reports nothing.
- R4: At the third level, other-invalid reports flag bit 0 and divide-by-zero reports flag bit 2. If any reported third-level condition is unmasked, lower levels of that lane are not reported. If all of them are masked, arbitration continues.
- R5: Denormal reports flag bit 1. If it is unmasked, lower levels of that lane are not reported. If it is masked, arbitration continues.
- R6: Overflow reports flag bit 3 and underflow reports flag bit 4. Inexact (flag bit 5) is reported with them only when all reported overflow and underflow conditions are masked. Inexact on its own is always reported.
- R7: The sticky flags become the OR of the reported conditions of all active lanes, visible the cycle after `op_valid_i`. They hold until the matching `clr_i` bit is high. A new report in the same cycle as a clear wins.
- R8: `trap_o` is high in the same cycle as `op_valid_i` exactly when some reported condition has its mask bit low. `cause_o` is then the reported conditions AND NOT `mask_i`, and it is zero whenever `trap_o` is low. Mask, flag and cause vectors share the bit order inv, den, dz, ovf, unf, inx (bits 0 to 5), and a mask bit of 1 means masked.
- R9: Without `op_valid_i` there is no trap and no flag is set. This includes clearing a mask bit whose flag is already set.
- R10: When `lane_cnt4_i` is 0, only lanes 0 and 1 are active, and the conditions of lanes 2 and 3 affect neither the flags, the trap nor the cause. When it is 1, all four lanes are active.
- R11: After reset the flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | A packed operation completes this cycle |
| lane_cnt4_i | input | 1 | 1 for four active lanes, 0 for two |
| any_nan_inv_i | input | 1 | Operation class that treats any NaN as invalid |
| cond_i | input | 8*MAX_LANES | Raw condition bits, eight per lane |
| mask_i | input | 6 | Mask bits, 1 means masked |
| clr_i | input | 6 | Per-bit clear of the sticky flags |
| flags_o | output | 6 | Sticky exception flags |
| trap_o | output | 1 | Precise trap request |
| cause_o | output | 6 | Unmasked reported condition classes |

## Verification
Directed patterns stack several conditions in one lane, once with every mask set and once with one mask cleared. This separates a design that stops after the winner from one that lets masked winners pass lower conditions. Spreading conditions over different lanes, and into lanes 2 and 3 under both lane counts, shows whether lanes leak into each other or are correctly ignored. Cycles with no strobe, mask changes over set flags, and clear/set collisions separate the sticky register from the trap path. Long randomized runs with sparse condition bits are compared every clock against a behavioural model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int COND_W = 8;
    localparam int FLAG_W = 6;

    // condition bit positions inside one lane
    localparam int C_SNAN = 0;
    localparam int C_QNAN = 1;
    localparam int C_OINV = 2;
    localparam int C_DZ   = 3;
    localparam int C_DEN  = 4;
    localparam int C_OVF  = 5;
    localparam int C_UNF  = 6;
    localparam int C_INX  = 7;

    // flag / mask / cause bit positions
    localparam int F_INV = 0;
    localparam int F_DEN = 1;
    localparam int F_DZ  = 2;
    localparam int F_OVF = 3;
    localparam int F_UNF = 4;
    localparam int F_INX = 5;

    typedef logic [COND_W-1:0] cond_vec_t;
    typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/fpx_lane_arb.sv
module fpx_lane_arb
    import fpx_pkg::*;
(
    input  cond_vec_t cond_i,
    input  logic      any_nan_inv_i,
    input  logic      lane_en_i,
    input  flag_vec_t mask_i,
    output flag_vec_t rep_o
);
    logic      hit_top, hit_quiet;
    logic      go_mid, go_den, go_rng, go_inx;
    flag_vec_t mid_rep, rng_rep;

    always_comb begin
        // levels one and two end arbitration for the lane
        hit_top   = lane_en_i & (cond_i[C_SNAN] | (any_nan_inv_i & cond_i[C_QNAN]));
        hit_quiet = lane_en_i & cond_i[C_QNAN] & ~any_nan_inv_i;
        go_mid    = lane_en_i & ~hit_top & ~hit_quiet;

        mid_rep        = '0;
        mid_rep[F_INV] = cond_i[C_OINV];
        mid_rep[F_DZ]  = cond_i[C_DZ];
        go_den = go_mid & ~(|(mid_rep & ~mask_i));
        go_rng = go_den & ~(cond_i[C_DEN] & ~mask_i[F_DEN]);

        rng_rep        = '0;
        rng_rep[F_OVF] = cond_i[C_OVF];
        rng_rep[F_UNF] = cond_i[C_UNF];
        go_inx = go_rng & ~(|(rng_rep & ~mask_i));

        rep_o        = '0;
        rep_o[F_INV] = hit_top;
        if (go_mid) rep_o = rep_o | mid_rep;
        rep_o[F_DEN] = go_den & cond_i[C_DEN];
        if (go_rng) rep_o = rep_o | rng_rep;
        rep_o[F_INX] = go_inx & cond_i[C_INX];
    end
endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky
    import fpx_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  flag_vec_t set_i,
    input  flag_vec_t clr_i,
    output flag_vec_t flags_o
);
    flag_vec_t flags_q, flags_d;

    always_comb flags_d = (flags_q & ~clr_i) | set_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flags_q <= '0;
        else         flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((($past(flags_q) & ~$past(clr_i)) & ~flags_q) == '0)); // R7
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(set_i) & ~flags_q) == '0)); // R7
    AST_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0)); // R9
endmodule

// File: rtl/fpx_arbiter.sv
module fpx_arbiter
    import fpx_pkg::*;
#(
    parameter int MAX_LANES = 4
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        op_valid_i,
    input  logic                        lane_cnt4_i,
    input  logic                        any_nan_inv_i,
    input  logic [MAX_LANES*COND_W-1:0] cond_i,
    input  logic [FLAG_W-1:0]           mask_i,
    input  logic [FLAG_W-1:0]           clr_i,
    output logic [FLAG_W-1:0]           flags_o,
    output logic                        trap_o,
    output logic [FLAG_W-1:0]           cause_o
);
    localparam int HALF = MAX_LANES / 2;

    flag_vec_t lane_rep [MAX_LANES];
    logic [MAX_LANES-1:0] lane_en;
    flag_vec_t merged, unmasked, set_vec;

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
        assign lane_en[l] = lane_cnt4_i | (l < HALF);

        fpx_lane_arb u_arb (
            .cond_i        (cond_i[l*COND_W +: COND_W]),
            .any_nan_inv_i (any_nan_inv_i),
            .lane_en_i     (lane_en[l]),
            .mask_i        (mask_i),
            .rep_o         (lane_rep[l])
        );

        AST_LANE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !lane_en[l] |-> (lane_rep[l] == '0)); // R10
        AST_TOP_ONLY_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lane_en[l] && cond_i[l*COND_W + C_SNAN]) |-> (lane_rep[l] == flag_vec_t'(1))); // R2
        AST_QNAN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!any_nan_inv_i && cond_i[l*COND_W + C_QNAN] && !cond_i[l*COND_W + C_SNAN])
                |-> (lane_rep[l] == '0)); // R3
    end

    always_comb begin
        merged = '0;
        for (int l = 0; l < MAX_LANES; l++) merged = merged | lane_rep[l];
        unmasked = merged & ~mask_i;
        trap_o   = op_valid_i & (|unmasked);
        cause_o  = trap_o ? unmasked : '0;
        set_vec  = op_valid_i ? merged : '0;
    end

    fpx_sticky u_sticky (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (set_vec),
        .clr_i   (clr_i),
        .flags_o (flags_o)
    );

    AST_TRAP_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> op_valid_i); // R9
    AST_CAUSE_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> (((cause_o & mask_i) == '0) && (cause_o != '0))); // R8
    AST_CAUSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_o |-> (cause_o == '0)); // R8
endmodule

// File: tb/fpx_arbiter_tb_top.sv
`timescale 1ns/1ps
module fpx_arbiter_tb_top;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, cnt4 = 1'b0, anynan = 1'b0;
    logic [31:0] cond = '0;
    logic [5:0]  mask = '0, clr = '0;
    logic [5:0]  flags, cause;
    logic        trap;

    int compared = 0, mismatched = 0;
    logic [5:0] model_flags = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fpx_arbiter #(.MAX_LANES(NL)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .lane_cnt4_i(cnt4),
        .any_nan_inv_i(anynan), .cond_i(cond), .mask_i(mask), .clr_i(clr),
        .flags_o(flags), .trap_o(trap), .cause_o(cause)
    );

    function automatic logic [5:0] ref_lane(input logic [7:0] c, input logic an, input logic [5:0] m);
        logic [5:0] r = '0;
        if (c[0] || (an && c[1])) return 6'b000001;
        if (c[1]) return '0;
        if (c[2]) r[0] = 1'b1;
        if (c[3]) r[2] = 1'b1;
        if ((r & ~m) != 0) return r;
        if (c[4]) begin
            r[1] = 1'b1;
            if (!m[1]) return r;
        end
        if (c[5]) r[3] = 1'b1;
        if (c[6]) r[4] = 1'b1;
        if ((r[4:3] & ~m[4:3]) != 0) return r;
        if (c[7]) r[5] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [5:0] act, input logic [5:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] c, input logic [5:0] m, input logic v,
                        input logic c4, input logic an, input logic [5:0] cl, input string tag);
        logic [5:0] merged = '0;
        logic [5:0] exp_cause;
        logic exp_trap;
        int n;
        @(negedge clk);
        cond = c; mask = m; valid = v; cnt4 = c4; anynan = an; clr = cl;
        n = c4 ? 4 : 2;
        for (int l = 0; l < n; l++) merged |= ref_lane(c[8*l +: 8], an, m);
        exp_trap  = v && ((merged & ~m) != 0);
        exp_cause = exp_trap ? (merged & ~m) : '0;
        #1;
        chk(tag, "trap", {5'b0, trap}, {5'b0, exp_trap});
        chk(tag, "cause", cause, exp_cause);
        model_flags = (model_flags & ~cl) | (v ? merged : 6'b0);
        @(posedge clk); #1;
        chk(tag, "flags", flags, model_flags);
    endtask

    task automatic wipe();
        step('0, 6'h3F, 1'b0, 1'b1, 1'b0, 6'h3F, "R7");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 chk("R11", "flags in reset", flags, 6'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 chk("R11", "flags after reset", flags, 6'b0);

        // R2: SNaN with dz and inexact, all masked -> invalid only
        step(32'h0000_0089, 6'h3F, 1, 0, 0, 0, "R2");
        wipe();
        step(32'h0000_0089, 6'h3E, 1, 0, 0, 0, "R2");
        wipe();
        // R3: QNaN with divide-by-zero unmasked -> nothing; promoted -> invalid
        step(32'h0000_000A, 6'h00, 1, 0, 0, 0, "R3");
        step(32'h0000_000A, 6'h3F, 1, 0, 1, 0, "R3");
        wipe();
        // R1: invalid in lane 0, dz in lane 1
        step(32'h0000_0804, 6'h3F, 1, 0, 0, 0, "R1");
        step(32'h0000_0804, 6'h00, 1, 0, 0, 0, "R1");
        wipe();
        // R4: other invalid + denormal + inexact
        step(32'h0000_0094, 6'h3F, 1, 0, 0, 0, "R4");
        wipe();
        step(32'h0000_0094, 6'h3E, 1, 0, 0, 0, "R4");
        wipe();
        // R5: denormal + overflow
        step(32'h0000_0030, 6'h3D, 1, 0, 0, 0, "R5");
        wipe();
        step(32'h0000_0030, 6'h3F, 1, 0, 0, 0, "R5");
        wipe();
        // R6: overflow/underflow with inexact
        step(32'h0000_00A0, 6'h3F, 1, 0, 0, 0, "R6");
        wipe();
        step(32'h0000_00A0, 6'h37, 1, 0, 0, 0, "R6");
        wipe();
        step(32'h0000_0080, 6'h00, 1, 0, 0, 0, "R6");
        // R7: hold, partial clear, set wins over clear
        step('0, 6'h3F, 0, 0, 0, 6'h00, "R7");
        step('0, 6'h3F, 0, 0, 0, 6'h20, "R7");
        step(32'h0000_0008, 6'h3F, 1, 0, 0, 6'h04, "R7");
        step(32'h0000_0008, 6'h3F, 1, 0, 0, 6'h04, "R7");
        // R9: flags set, masks cleared, no strobe -> no trap, no change
        step(32'h0000_00FF, 6'h00, 0, 1, 0, 0, "R9");
        step(32'hFFFF_FFFF, 6'h00, 0, 1, 1, 0, "R9");
        wipe();
        // R10: lanes 2 and 3 ignored in two-lane mode, used in four-lane mode
        step(32'h0408_0000, 6'h00, 1, 0, 0, 0, "R10");
        step(32'h0408_0000, 6'h00, 1, 1, 0, 0, "R10");
        wipe();
        // R8: randomized comparison against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] c = $urandom & $urandom & $urandom;
            logic [5:0]  m = 6'($urandom);
            logic [5:0]  cl = (($urandom % 8) == 0) ? 6'($urandom) : 6'b0;
            step(c, m, ($urandom % 4) != 0, 1'($urandom), ($urandom % 4) == 0, cl, "R8");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule